// File: doc/BRIEF.md
# Ladder-Logic Boolean Instruction Processor

This block runs a stored relay-ladder program, one instruction per clock. It works over a 256-bit, bit-addressed I/O memory. A host loads 16-bit instruction words into an internal program store through a write port. The host also places input bits into the bit memory and reads result bits back through a separate port. Addresses 0 to 63 are meant for inputs, 64 to 127 for outputs, and 128 to 255 for internal work bits. The processor does not enforce this map.

Each instruction word has an opcode in bits 15:8 and a bit address in bits 7:0. The engine holds three pieces of rung state:
- an execution condition;
- an 8-deep stack of earlier block results, used for block AND/OR and for latches;
- flags for an interlocked region and a skipped (jump) region.

A scan runs from program address 0 up to the END instruction. END produces a one-cycle scan-done pulse. The scan then starts over, or, if run is low, the engine halts before the next scan.

The sequencer has three states:
- HALT: idle, with the program counter at 0.
- SCAN: one instruction executes per cycle.
- WRAP: the cycle after END, in which scan_done is high.

The transitions are:
- HALT→SCAN when run is high.
- SCAN→WRAP when END executes.
- WRAP→SCAN when run is high.
- WRAP→HALT when run is low.

Top module: `ladder_proc`

## Requirements
- R1: The load, AND and OR opcodes set the condition to the addressed bit, cond&bit and cond|bit. The inverted forms use the inverted bit. Opcodes: load 0x20, load-inverted 0x21, AND 0x22, AND-inverted 0x23, OR 0x24, OR-inverted 0x25.
- R2: Output (0x28) writes the condition to the addressed bit. Inverted output (0x29) writes its inverse. The condition is kept, so several outputs may follow one rung.
- R3: A load pushes the previous condition onto the stack, except for the first load of a rung. A rung starts at reset, after END, and after any output, latch, interlock or jump opcode. Block-AND (0x26) and block-OR (0x27) pop one entry and combine it with the condition.
- R4: Set (0x2A) writes 1 and reset (0x2B) writes 0 to the addressed bit when the condition is 1. Both leave the bit unchanged when the condition is 0.
- R5: The latch opcode (0x0B) pops the stack as its set input and uses the condition as its reset input. Reset wins over set. With both inputs at 0 the bit holds.
- R6: The interlock opcode (0x02) takes the condition as the region condition. The region ends at interlock-clear (0x03). While the region condition is 0, output and inverted output write 0, and every other opcode except interlock-clear, jump-end and END does nothing.
- R7: The jump opcode (0x04) starts a skipped region when the condition is 0. The region ends at jump-end (0x05). Inside it, nothing except jump-end and END executes, and no bit changes.
- R8: A push onto a full 8-entry stack, or a pop from an empty one, sets stack_err. stack_err stays set until reset. Eight pushes in a rung do not set it.
- R9: END (0x01) returns the program counter to 0 and clears the stack and region flags. scan_done is high for exactly one cycle. A program of N words including END takes N+1 cycles per scan, both from a halted start and in continuous running.
- R10: With run low, the block halts after a scan. No instruction executes, scan_done stays low, and changes to inputs leave the outputs unchanged.
- R11: After reset every memory bit reads 0 and stack_err is 0. A host write sets the addressed bit, and host_rdata shows the addressed bit combinationally.
- R12: No-op (0x00) and every unlisted opcode change neither the condition nor any memory bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| run | input | 1 | High: scans repeat; low: halt after the current scan |
| prog_we | input | 1 | Program store write enable |
| prog_addr | input | 6 | Program store write address |
| prog_wdata | input | 16 | Instruction word {opcode, bit address} |
| host_we | input | 1 | Bit memory host write enable |
| host_waddr | input | 8 | Bit memory host write address |
| host_wdata | input | 1 | Bit memory host write value |
| host_raddr | input | 8 | Bit memory host read address |
| host_rdata | output | 1 | Bit memory host read value |
| scan_done | output | 1 | One-cycle pulse after END |
| stack_err | output | 1 | Sticky stack overflow/underflow flag |

## Verification
The assertions check four things on every cycle:
- scan_done never lasts two cycles and always coincides with a zero program counter;
- the stack pointer stays within its depth, and the error flag never drops;
- an interlocked region writes only zeros, and a skipped region writes nothing;
- a halted engine with run low executes nothing.

Only the bench scenarios can show the actual Boolean results, the block-combining order, latch holding across scans, and scan lengths in cycles. The bench checks these against a model of each rung over a sequence of input patterns chosen to exercise holds and priorities.

// File: rtl/ladder_pkg.sv
`timescale 1ns/1ps
package ladder_pkg;
    localparam int OPW = 8;
    localparam int BAW = 8;

    localparam logic [OPW-1:0] OP_NOP   = 8'h00;
    localparam logic [OPW-1:0] OP_END   = 8'h01;
    localparam logic [OPW-1:0] OP_IL    = 8'h02;
    localparam logic [OPW-1:0] OP_ILC   = 8'h03;
    localparam logic [OPW-1:0] OP_JMP   = 8'h04;
    localparam logic [OPW-1:0] OP_JME   = 8'h05;
    localparam logic [OPW-1:0] OP_LATCH = 8'h0B;
    localparam logic [OPW-1:0] OP_LD    = 8'h20;
    localparam logic [OPW-1:0] OP_LDN   = 8'h21;
    localparam logic [OPW-1:0] OP_AND   = 8'h22;
    localparam logic [OPW-1:0] OP_ANDN  = 8'h23;
    localparam logic [OPW-1:0] OP_OR    = 8'h24;
    localparam logic [OPW-1:0] OP_ORN   = 8'h25;
    localparam logic [OPW-1:0] OP_BAND  = 8'h26;
    localparam logic [OPW-1:0] OP_BOR   = 8'h27;
    localparam logic [OPW-1:0] OP_OUT   = 8'h28;
    localparam logic [OPW-1:0] OP_OUTN  = 8'h29;
    localparam logic [OPW-1:0] OP_SET   = 8'h2A;
    localparam logic [OPW-1:0] OP_RST   = 8'h2B;

    typedef enum logic [1:0] {
        ST_HALT = 2'd0,
        ST_SCAN = 2'd1,
        ST_WRAP = 2'd2
    } seq_state_e;
endpackage

// File: rtl/ladder_prog_ram.sv
`timescale 1ns/1ps
module ladder_prog_ram #(
    parameter int DEPTH = 64,
    parameter int WIDTH = 16,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] words [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            words[waddr] <= wdata;
        end
    end

    assign rdata = words[raddr];
endmodule

// File: rtl/ladder_bitmem.sv
`timescale 1ns/1ps
module ladder_bitmem #(
    parameter int AW = 8,
    localparam int NBITS = 1 << AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_we,
    input  logic [AW-1:0] host_waddr,
    input  logic          host_wdata,
    input  logic [AW-1:0] host_raddr,
    output logic          host_rdata,
    input  logic [AW-1:0] ex_raddr,
    output logic          ex_rdata,
    input  logic          ex_we,
    input  logic [AW-1:0] ex_waddr,
    input  logic          ex_wdata
);
    logic [NBITS-1:0] bits_q;

    // Execution write is placed last so it wins a same-cycle collision.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bits_q <= '0;
        end else begin
            if (host_we) begin
                bits_q[host_waddr] <= host_wdata;
            end
            if (ex_we) begin
                bits_q[ex_waddr] <= ex_wdata;
            end
        end
    end

    assign host_rdata = bits_q[host_raddr];
    assign ex_rdata   = bits_q[ex_raddr];
endmodule

// File: rtl/ladder_bstack.sv
`timescale 1ns/1ps
module ladder_bstack #(
    parameter int DEPTH = 8,
    localparam int SPW = $clog2(DEPTH + 1),
    localparam int IW  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic           push,
    input  logic           pop,
    input  logic           din,
    output logic           top,
    output logic [SPW-1:0] sp_o,
    output logic           err
);
    logic [DEPTH-1:0] slots_q;
    logic [SPW-1:0]   sp_q;
    logic             full, empty;
    logic [IW-1:0]    wr_idx, rd_idx;

    assign full   = (sp_q == SPW'(DEPTH));
    assign empty  = (sp_q == '0);
    assign wr_idx = IW'(sp_q);
    assign rd_idx = IW'(sp_q - SPW'(1));
    assign top    = empty ? 1'b0 : slots_q[rd_idx];
    assign sp_o   = sp_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slots_q <= '0;
            sp_q    <= '0;
            err     <= 1'b0;
        end else begin
            err <= err | (push & full) | (pop & empty);
            if (clr) begin
                sp_q <= '0;
            end else if (push && !full) begin
                slots_q[wr_idx] <= din;
                sp_q            <= sp_q + SPW'(1);
            end else if (pop && !empty) begin
                sp_q <= sp_q - SPW'(1);
            end
        end
    end
endmodule

// File: rtl/ladder_proc.sv
`timescale 1ns/1ps
module ladder_proc
    import ladder_pkg::*;
#(
    parameter int PROG_DEPTH  = 64,
    parameter int STACK_DEPTH = 8,
    localparam int PC_W = (PROG_DEPTH > 1) ? $clog2(PROG_DEPTH) : 1,
    localparam int IW   = OPW + BAW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            prog_we,
    input  logic [PC_W-1:0] prog_addr,
    input  logic [IW-1:0]   prog_wdata,
    input  logic            host_we,
    input  logic [BAW-1:0]  host_waddr,
    input  logic            host_wdata,
    input  logic [BAW-1:0]  host_raddr,
    output logic            host_rdata,
    output logic            scan_done,
    output logic            stack_err
);
    localparam int SP_W = $clog2(STACK_DEPTH + 1);

    seq_state_e      state_q, state_d;
    logic [PC_W-1:0] pc_q;
    logic            cond_q, cond_d;
    logic            rung_q, rung_d;
    logic            il_on_q, il_on_d;
    logic            il_cond_q, il_cond_d;
    logic            jmp_skip_q, jmp_skip_d;

    logic [IW-1:0]   instr;
    logic [OPW-1:0]  op;
    logic [BAW-1:0]  baddr;
    logic            bitv;
    logic            exec, il_block, is_end;
    logic            ex_we, ex_wdata;
    logic            stk_push, stk_pop, stk_clr, stk_top;
    logic [SP_W-1:0] stk_sp;

    ladder_prog_ram #(.DEPTH(PROG_DEPTH), .WIDTH(IW)) u_prog (
        .clk   (clk),
        .we    (prog_we),
        .waddr (prog_addr),
        .wdata (prog_wdata),
        .raddr (pc_q),
        .rdata (instr)
    );

    ladder_bitmem #(.AW(BAW)) u_mem (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (host_we),
        .host_waddr (host_waddr),
        .host_wdata (host_wdata),
        .host_raddr (host_raddr),
        .host_rdata (host_rdata),
        .ex_raddr   (baddr),
        .ex_rdata   (bitv),
        .ex_we      (ex_we),
        .ex_waddr   (baddr),
        .ex_wdata   (ex_wdata)
    );

    ladder_bstack #(.DEPTH(STACK_DEPTH)) u_stack (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (stk_clr),
        .push  (stk_push),
        .pop   (stk_pop),
        .din   (cond_q),
        .top   (stk_top),
        .sp_o  (stk_sp),
        .err   (stack_err)
    );

    assign op       = instr[IW-1:BAW];
    assign baddr    = instr[BAW-1:0];
    assign exec     = (state_q == ST_SCAN);
    assign il_block = il_on_q & ~il_cond_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HALT;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT: state_d = run ? ST_SCAN : ST_HALT;
            ST_SCAN: state_d = is_end ? ST_WRAP : ST_SCAN;
            ST_WRAP: state_d = run ? ST_SCAN : ST_HALT;
            default: state_d = ST_HALT;
        endcase
    end

    // Outputs of the sequencer
    always_comb begin
        scan_done = (state_q == ST_WRAP);
    end

    // Instruction decode and execute
    always_comb begin
        cond_d     = cond_q;
        rung_d     = rung_q;
        il_on_d    = il_on_q;
        il_cond_d  = il_cond_q;
        jmp_skip_d = jmp_skip_q;
        ex_we      = 1'b0;
        ex_wdata   = 1'b0;
        stk_push   = 1'b0;
        stk_pop    = 1'b0;
        stk_clr    = 1'b0;
        is_end     = 1'b0;
        if (exec) begin
            if (op == OP_END) begin
                is_end     = 1'b1;
                stk_clr    = 1'b1;
                cond_d     = 1'b0;
                rung_d     = 1'b1;
                il_on_d    = 1'b0;
                jmp_skip_d = 1'b0;
            end else if (jmp_skip_q) begin
                if (op == OP_JME) begin
                    jmp_skip_d = 1'b0;
                    stk_clr    = 1'b1;
                    rung_d     = 1'b1;
                end
            end else if (il_block) begin
                case (op)
                    OP_OUT, OP_OUTN: begin
                        ex_we    = 1'b1;
                        ex_wdata = 1'b0;
                    end
                    OP_ILC: begin
                        il_on_d = 1'b0;
                        stk_clr = 1'b1;
                        rung_d  = 1'b1;
                    end
                    OP_JME: begin
                        jmp_skip_d = 1'b0;
                    end
                    default: begin
                    end
                endcase
            end else begin
                case (op)
                    OP_LD, OP_LDN: begin
                        stk_push = ~rung_q;
                        cond_d   = bitv ^ (op == OP_LDN);
                        rung_d   = 1'b0;
                    end
                    OP_AND:  cond_d = cond_q & bitv;
                    OP_ANDN: cond_d = cond_q & ~bitv;
                    OP_OR:   cond_d = cond_q | bitv;
                    OP_ORN:  cond_d = cond_q | ~bitv;
                    OP_BAND: begin
                        stk_pop = 1'b1;
                        cond_d  = cond_q & stk_top;
                    end
                    OP_BOR: begin
                        stk_pop = 1'b1;
                        cond_d  = cond_q | stk_top;
                    end
                    OP_OUT, OP_OUTN: begin
                        ex_we    = 1'b1;
                        ex_wdata = cond_q ^ (op == OP_OUTN);
                        stk_clr  = 1'b1;
                        rung_d   = 1'b1;
                    end
                    OP_SET, OP_RST: begin
                        ex_we    = cond_q;
                        ex_wdata = (op == OP_SET);
                        stk_clr  = 1'b1;
                        rung_d   = 1'b1;
                    end
                    OP_LATCH: begin
                        stk_pop  = 1'b1;
                        ex_we    = 1'b1;
                        ex_wdata = cond_q ? 1'b0 : (stk_top | bitv);
                        stk_clr  = 1'b1;
                        rung_d   = 1'b1;
                    end
                    OP_IL: begin
                        il_on_d   = 1'b1;
                        il_cond_d = cond_q;
                        stk_clr   = 1'b1;
                        rung_d    = 1'b1;
                    end
                    OP_ILC: begin
                        il_on_d = 1'b0;
                        stk_clr = 1'b1;
                        rung_d  = 1'b1;
                    end
                    OP_JMP: begin
                        jmp_skip_d = ~cond_q;
                        stk_clr    = 1'b1;
                        rung_d     = 1'b1;
                    end
                    OP_JME: begin
                        jmp_skip_d = 1'b0;
                        stk_clr    = 1'b1;
                        rung_d     = 1'b1;
                    end
                    default: begin
                    end
                endcase
            end
        end
    end

    // Rung state and program counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q       <= '0;
            cond_q     <= 1'b0;
            rung_q     <= 1'b1;
            il_on_q    <= 1'b0;
            il_cond_q  <= 1'b0;
            jmp_skip_q <= 1'b0;
        end else begin
            cond_q     <= cond_d;
            rung_q     <= rung_d;
            il_on_q    <= il_on_d;
            il_cond_q  <= il_cond_d;
            jmp_skip_q <= jmp_skip_d;
            if (exec) begin
                pc_q <= is_end ? '0 : pc_q + PC_W'(1);
            end
        end
    end
endmodule

// File: rtl/ladder_proc_chk.sv
`timescale 1ns/1ps
module ladder_proc_chk
    import ladder_pkg::*;
#(
    parameter int PCW    = 6,
    parameter int SPW    = 4,
    parameter int SDEPTH = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           run,
    input logic           scan_done,
    input logic           stack_err,
    input seq_state_e     state,
    input logic [PCW-1:0] pc,
    input logic [SPW-1:0] sp,
    input logic           il_block,
    input logic           jmp_skip,
    input logic           ex_we,
    input logic           ex_wdata
);
    // R9
    scan_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scan_done |=> !scan_done);

    // R9
    wrap_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scan_done |-> (pc == '0));

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stack_err |=> stack_err);

    // R8
    sp_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sp <= SPW'(SDEPTH));

    // R6
    il_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (il_block && ex_we) |-> !ex_wdata);

    // R7
    jmp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        jmp_skip |-> !ex_we);

    // R10
    halt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT && !run) |=> (!ex_we && !scan_done));
endmodule

bind ladder_proc ladder_proc_chk #(
    .PCW    (PC_W),
    .SPW    (SP_W),
    .SDEPTH (STACK_DEPTH)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .scan_done (scan_done),
    .stack_err (stack_err),
    .state     (state_q),
    .pc        (pc_q),
    .sp        (stk_sp),
    .il_block  (il_block),
    .jmp_skip  (jmp_skip_q),
    .ex_we     (ex_we),
    .ex_wdata  (ex_wdata)
);

// File: tb/test_ladder_proc.sv
`timescale 1ns/1ps
module test_ladder_proc;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run = 1'b0;
    logic       prog_we = 1'b0;
    logic [5:0] prog_addr = '0;
    logic [15:0] prog_wdata = '0;
    logic       host_we = 1'b0;
    logic [7:0] host_waddr = '0;
    logic       host_wdata = 1'b0;
    logic [7:0] host_raddr;
    logic       host_rdata;
    logic       scan_done;
    logic       stack_err;

    int checks = 0;
    int fails  = 0;
    int ptr    = 0;
    bit m69 = 0, m70 = 0, m72 = 0;
    bit last64 = 0;

    typedef struct {
        int    addr;
        bit    val;
        string tag;
    } exp_t;
    exp_t exp_q[$];

    always #5 clk = ~clk;

    ladder_proc i_ladder_proc (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .prog_we    (prog_we),
        .prog_addr  (prog_addr),
        .prog_wdata (prog_wdata),
        .host_we    (host_we),
        .host_waddr (host_waddr),
        .host_wdata (host_wdata),
        .host_raddr (host_raddr),
        .host_rdata (host_rdata),
        .scan_done  (scan_done),
        .stack_err  (stack_err)
    );

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic expect_bit(int addr, bit val, string tag);
        exp_t e;
        e.addr = addr;
        e.val  = val;
        e.tag  = tag;
        exp_q.push_back(e);
    endtask

    // Monitor: pops expectations and compares the bit memory read port
    initial begin
        host_raddr = '0;
        forever begin
            @(negedge clk);
            if (exp_q.size() > 0) begin : pop_one
                exp_t e;
                e = exp_q.pop_front();
                host_raddr = 8'(e.addr);
                #1;
                check(host_rdata === e.val, e.tag, int'(host_rdata), int'(e.val));
            end
        end
    end

    task automatic drain();
        while (exp_q.size() > 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        run   = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        ptr = 0;
    endtask

    task automatic add(logic [7:0] op, logic [7:0] a);
        prog_addr  = 6'(ptr);
        prog_wdata = {op, a};
        prog_we    = 1'b1;
        @(negedge clk);
        prog_we = 1'b0;
        ptr++;
    endtask

    task automatic set_in(int a, bit v);
        host_waddr = 8'(a);
        host_wdata = v;
        host_we    = 1'b1;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic run_scan(output int cyc);
        run = 1'b1;
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (!scan_done && cyc < 1000);
        run = 1'b0;
    endtask

    task automatic apply_vec(logic [10:0] v);
        for (int k = 0; k < 11; k++) set_in(k, v[k]);
    endtask

    task automatic scan_and_check(logic [10:0] v);
        int cyc;
        bit i0, i1;
        apply_vec(v);
        i0 = v[0];
        i1 = v[1];
        run_scan(cyc);
        check(cyc == ptr + 1, "R9 scan length", cyc, ptr + 1);
        @(negedge clk);
        check(scan_done == 1'b0, "R9 pulse width", int'(scan_done), 0);
        if (v[5]) m69 = 1;
        if (v[6]) m69 = 0;
        if (v[8]) m70 = 0;
        else if (v[7]) m70 = 1;
        if (v[10]) m72 = i0;
        last64 = i0 & i1;
        expect_bit(64, i0 & i1, "R1 R12 and-chain");
        expect_bit(65, !i0 | !i1, "R1 inverted or");
        expect_bit(66, i0 & i1, "R2 inverted output");
        expect_bit(67, v[2] & (v[3] | v[4]), "R3 block and");
        expect_bit(68, i0 | i1, "R3 block or");
        expect_bit(69, m69, "R4 set/reset");
        expect_bit(70, m70, "R5 latch");
        expect_bit(71, v[9] ? i0 : 1'b0, "R6 interlock");
        expect_bit(72, m72, "R7 jump hold");
        drain();
    endtask

    localparam logic [7:0] LD = 8'h20, LDN = 8'h21, AND_ = 8'h22, ORN = 8'h25,
                           OR_ = 8'h24, BAND = 8'h26, BOR = 8'h27, OUT = 8'h28,
                           OUTN = 8'h29, SET = 8'h2A, RST = 8'h2B, LATCH = 8'h0B,
                           IL = 8'h02, ILC = 8'h03, JMP = 8'h04, JME = 8'h05,
                           END_ = 8'h01, NOP = 8'h00;

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : driver
        int cyc;
        logic [10:0] vecs [11];
        vecs = '{11'h000, 11'h483, 11'h12A, 11'h7FF, 11'h0C1, 11'h001,
                 11'h300, 11'h5D4, 11'h020, 11'h000, 11'h040};
        do_reset();
        // R11 reset state
        check(scan_done == 1'b0, "R11 reset scan_done", int'(scan_done), 0);
        check(stack_err == 1'b0, "R11 reset stack_err", int'(stack_err), 0);
        expect_bit(64, 0, "R11 reset bit");
        expect_bit(250, 0, "R11 reset work bit");
        set_in(200, 1);
        expect_bit(200, 1, "R11 host write");
        expect_bit(201, 0, "R11 neighbour untouched");
        drain();

        // Program covering every opcode family
        add(LD, 0);  add(AND_, 1); add(OUT, 64);
        add(NOP, 64); add(8'hFF, 64);
        add(LDN, 0); add(ORN, 1); add(OUT, 65); add(OUTN, 66);
        add(LD, 2);  add(LD, 3);  add(OR_, 4); add(BAND, 0); add(OUT, 67);
        add(LD, 0);  add(LD, 1);  add(BOR, 0); add(OUT, 68);
        add(LD, 5);  add(SET, 69); add(LD, 6); add(RST, 69);
        add(LD, 7);  add(LD, 8);  add(LATCH, 70);
        add(LD, 9);  add(IL, 0);  add(LD, 0); add(OUT, 71); add(ILC, 0);
        add(LD, 10); add(JMP, 0); add(LD, 0); add(OUT, 72); add(JME, 0);
        add(END_, 0);

        foreach (vecs[n]) scan_and_check(vecs[n]);
        check(stack_err == 1'b0, "R8 no false error", int'(stack_err), 0);

        // R10: halted, inputs change, nothing executes
        set_in(0, !vecs[10][0]);
        set_in(1, 1'b1);
        cyc = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (scan_done) cyc++;
        end
        check(cyc == 0, "R10 no scan while halted", cyc, 0);
        expect_bit(64, last64, "R10 output frozen");
        drain();

        // R9 continuous running period
        run = 1'b1;
        cyc = 0;
        while (!scan_done && cyc < 1000) begin
            @(negedge clk);
            cyc++;
        end
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (!scan_done && cyc < 1000);
        run = 1'b0;
        check(cyc == ptr + 1, "R9 continuous period", cyc, ptr + 1);
        repeat (3) @(negedge clk);

        // R8: eight pushes are legal
        do_reset();
        for (int k = 0; k < 9; k++) add(LD, 8'(k));
        add(END_, 0);
        run_scan(cyc);
        @(negedge clk);
        check(stack_err == 1'b0, "R8 full depth no error", int'(stack_err), 0);

        // R8: ninth push overflows
        ptr = 0;
        for (int k = 0; k < 10; k++) add(LD, 8'(k));
        add(END_, 0);
        run_scan(cyc);
        @(negedge clk);
        check(stack_err == 1'b1, "R8 overflow", int'(stack_err), 1);
        repeat (5) @(negedge clk);
        check(stack_err == 1'b1, "R8 sticky", int'(stack_err), 1);

        // R8: pop from empty stack underflows
        do_reset();
        add(LD, 0); add(BAND, 0); add(OUT, 64); add(END_, 0);
        run_scan(cyc);
        @(negedge clk);
        check(stack_err == 1'b1, "R8 underflow", int'(stack_err), 1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule